// File: doc/BRIEF.md
# GPIO Port with Peripheral Override

This block controls a six-pin general-purpose I/O port. Five pins are bidirectional and the sixth is input-only. Software reaches the port through a small register interface. It holds an output latch, a direction register and an analog-select register, and it can read back the synchronized pin levels. Peripherals attached to the port can take over a pin's output data. They can also force a pin's direction either way. These overrides never change what software stored in the direction register.

Extra controls change what reaches the pads. A segment-drive enable takes pin 4 away from the port. A configuration bit decides whether the input-only pin reads as a port input. Open-drain driving can be enabled separately for the capture/PWM pin and the serial-transmit pin. A shutdown event can float the PWM pin. For every bidirectional pin the block produces a drive value, an output enable and an open-drain flag. It also returns the synchronized pin inputs for use by the peripherals.

Top module: `gpio_port_ovr`

## Requirements
- R1: After reset the direction register (address 2) reads 0x1F, the latch register (address 1) reads 0x00 and the analog-select register (address 3) reads 0x1F.
- R2: A write with `reg_wr` high stores `reg_wdata[4:0]` into the register at `reg_addr` at the next clock edge: address 1 is the latch, 2 the direction, 3 the analog select. A write to address 0 changes no register. Register reads return the stored bits in [4:0] with [7:5] at zero.
- R3: Reading address 0 returns the pin levels from two clock edges earlier. Bit i (0..4) reads 0 while analog-select bit i is 1. Bits [7:6] read 0.
- R4: With no peripheral override, `pad_out[i]` equals latch bit i and `pad_oe[i]` is the inverse of direction bit i (direction 1 = input). The analog select does not change either one.
- R5: While `per_out_en[i]` is 1, `per_out_data[i]` replaces latch bit i on `pad_out[i]`.
- R6: `per_force_out[i]` sets the pin to output and `per_force_in[i]` sets it to input. If both are set, force-out wins. Neither one changes the direction register.
- R7: While `seg_en` is 1, `pad_oe[4]` is 0 and bit 4 of the port read is 0.
- R8: Bit 5 of the port read follows the synchronized `pad_in[5]` only while `rst_pin_off` is 1. Otherwise it reads 0.
- R9: On pin 0 with `od_pwm_en`, or on pin 1 with `od_tx_en`, while that pin's `per_out_en` is 1: `pad_od` is 1 and `pad_out` is 0. `pad_oe` is then asserted only when the pin would be an output and the selected data is 0.
- R10: While `shdn_active` and `per_out_en[0]` are both 1, `pad_oe[0]` is 0.
- R11: `pin_sync` equals `pad_in` delayed by two clock edges, with no analog, segment or reset-pin gating applied.

Ports table: `pad_in` bits 0..5 are the six pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 port, 1 latch, 2 direction, 3 analog) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| per_out_en | input | 5 | Peripheral owns output data of pin i |
| per_out_data | input | 5 | Peripheral output data |
| per_force_out | input | 5 | Peripheral forces pin to output |
| per_force_in | input | 5 | Peripheral forces pin to input |
| seg_en | input | 1 | Segment drive owns pin 4 |
| rst_pin_off | input | 1 | Reset function of pin 5 disabled |
| od_pwm_en | input | 1 | Open-drain for the capture/PWM output on pin 0 |
| od_tx_en | input | 1 | Open-drain for the serial transmit output on pin 1 |
| shdn_active | input | 1 | Shutdown event: float the PWM pin |
| pad_in | input | 6 | Raw pin levels |
| pad_out | output | 5 | Drive value per bidirectional pin |
| pad_oe | output | 5 | Output enable per bidirectional pin |
| pad_od | output | 5 | Open-drain indication per pin |
| pin_sync | output | 6 | Synchronized pin levels |

## Verification
The hardest case to reach is a pin where several controls act at once. Examples are a forced direction together with open-drain and a low data bit, or shutdown together with a forced output on pin 0. A separate case is confirming that a forced direction leaves the direction register as software wrote it.

Random stimulus sets each override bit with low probability, so these combinations occur alongside plain latch traffic. Directed steps then build each combination explicitly. After each one the bench reads the direction register back through the bus.

// File: rtl/gpio_ovr_pkg.sv
package gpio_ovr_pkg;
    localparam int NBIDIR = 5;
    localparam int NPIN   = NBIDIR + 1;
    localparam int DW     = 8;
    localparam int AW     = 2;

    typedef enum logic [AW-1:0] {
        ADDR_PORT = 2'd0,
        ADDR_LAT  = 2'd1,
        ADDR_DIR  = 2'd2,
        ADDR_ANA  = 2'd3
    } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;

    a_r11_second_stage: assert property (@(posedge clk) disable iff (!rst_n)
        sync_q == $past(meta_q));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_ovr_pkg::*;
#(
    parameter int NB = NBIDIR
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic [NB:0]   port_val,
    output logic [NB-1:0] lat_q,
    output logic [NB-1:0] dir_q,
    output logic [NB-1:0] ana_q,
    output logic [DW-1:0] rdata
);
    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '0;
            dir_q <= '1;
            ana_q <= '1;
        end else if (wr) begin
            unique case (sel)
                ADDR_LAT:  lat_q <= wdata[NB-1:0];
                ADDR_DIR:  dir_q <= wdata[NB-1:0];
                ADDR_ANA:  ana_q <= wdata[NB-1:0];
                ADDR_PORT: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        unique case (sel)
            ADDR_PORT: rdata[NB:0]   = port_val;
            ADDR_LAT:  rdata[NB-1:0] = lat_q;
            ADDR_DIR:  rdata[NB-1:0] = dir_q;
            ADDR_ANA:  rdata[NB-1:0] = ana_q;
        endcase
    end

    a_r6_dir_software_only: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && sel == ADDR_DIR) |=> $stable(dir_q));
    a_r2_lat_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == ADDR_LAT) |=> lat_q == $past(wdata[NB-1:0]));
    a_r2_port_write_inert: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && sel == ADDR_PORT) |=> ($stable(lat_q) && $stable(ana_q)));
endmodule

// File: rtl/gpio_pin_drv.sv
module gpio_pin_drv #(
    parameter int          NB        = 5,
    parameter logic [NB-1:0] PWM_MASK = 5'b00001,
    parameter logic [NB-1:0] TX_MASK  = 5'b00010,
    parameter int          SEG_PIN   = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NB-1:0] lat_q,
    input  logic [NB-1:0] dir_q,
    input  logic [NB-1:0] per_out_en,
    input  logic [NB-1:0] per_out_data,
    input  logic [NB-1:0] per_force_out,
    input  logic [NB-1:0] per_force_in,
    input  logic          seg_en,
    input  logic          od_pwm_en,
    input  logic          od_tx_en,
    input  logic          shdn_active,
    output logic [NB-1:0] pad_out,
    output logic [NB-1:0] pad_oe,
    output logic [NB-1:0] pad_od
);
    for (genvar i = 0; i < NB; i++) begin : g_pin
        localparam bit IS_PWM = PWM_MASK[i];
        localparam bit IS_TX  = TX_MASK[i];
        localparam bit IS_SEG = (i == SEG_PIN);

        logic drv_val;
        logic want_oe;
        logic od_sel;
        logic kill_oe;

        always_comb begin
            drv_val = per_out_en[i] ? per_out_data[i] : lat_q[i];
            if (per_force_out[i])
                want_oe = 1'b1;
            else if (per_force_in[i])
                want_oe = 1'b0;
            else
                want_oe = ~dir_q[i];
            od_sel  = per_out_en[i] & ((IS_PWM & od_pwm_en) | (IS_TX & od_tx_en));
            kill_oe = (IS_SEG & seg_en) | (IS_PWM & shdn_active & per_out_en[i]);

            pad_od[i]  = od_sel;
            pad_out[i] = od_sel ? 1'b0 : drv_val;
            if (kill_oe)
                pad_oe[i] = 1'b0;
            else if (od_sel)
                pad_oe[i] = want_oe & ~drv_val;
            else
                pad_oe[i] = want_oe;
        end

        a_r9_od_drives_low: assert property (@(posedge clk) disable iff (!rst_n)
            (pad_od[i] && pad_oe[i]) |-> !pad_out[i]);
    end

    a_r10_shutdown_float: assert property (@(posedge clk) disable iff (!rst_n)
        (shdn_active && (per_out_en & PWM_MASK) != '0) |-> (pad_oe & PWM_MASK) == '0);
    a_r7_segment_owns_pin: assert property (@(posedge clk) disable iff (!rst_n)
        seg_en |-> !pad_oe[SEG_PIN]);
endmodule

// File: rtl/gpio_port_ovr.sv
module gpio_port_ovr
    import gpio_ovr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [AW-1:0]     reg_addr,
    input  logic [DW-1:0]     reg_wdata,
    output logic [DW-1:0]     reg_rdata,
    input  logic [NBIDIR-1:0] per_out_en,
    input  logic [NBIDIR-1:0] per_out_data,
    input  logic [NBIDIR-1:0] per_force_out,
    input  logic [NBIDIR-1:0] per_force_in,
    input  logic              seg_en,
    input  logic              rst_pin_off,
    input  logic              od_pwm_en,
    input  logic              od_tx_en,
    input  logic              shdn_active,
    input  logic [NPIN-1:0]   pad_in,
    output logic [NBIDIR-1:0] pad_out,
    output logic [NBIDIR-1:0] pad_oe,
    output logic [NBIDIR-1:0] pad_od,
    output logic [NPIN-1:0]   pin_sync
);
    localparam int SEG_PIN = NBIDIR - 1;

    logic [NBIDIR-1:0] lat_q, dir_q, ana_q;
    logic [NPIN-1:0]   port_val;
    logic [NBIDIR-1:0] seg_mask;

    gpio_sync #(.W(NPIN)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pin_sync)
    );

    always_comb begin
        seg_mask          = '0;
        seg_mask[SEG_PIN] = seg_en;
        port_val[NBIDIR-1:0] = pin_sync[NBIDIR-1:0] & ~ana_q & ~seg_mask;
        port_val[NBIDIR]     = pin_sync[NBIDIR] & rst_pin_off;
    end

    gpio_regs #(.NB(NBIDIR)) i_regs (
        .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
        .wdata(reg_wdata), .port_val(port_val),
        .lat_q(lat_q), .dir_q(dir_q), .ana_q(ana_q), .rdata(reg_rdata)
    );

    gpio_pin_drv #(.NB(NBIDIR), .SEG_PIN(SEG_PIN)) i_drv (
        .clk(clk), .rst_n(rst_n), .lat_q(lat_q), .dir_q(dir_q),
        .per_out_en(per_out_en), .per_out_data(per_out_data),
        .per_force_out(per_force_out), .per_force_in(per_force_in),
        .seg_en(seg_en), .od_pwm_en(od_pwm_en), .od_tx_en(od_tx_en),
        .shdn_active(shdn_active),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_od(pad_od)
    );

    a_r8_reset_pin_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (!rst_pin_off && reg_addr == ADDR_PORT) |-> !reg_rdata[NBIDIR]);
    a_r3_port_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_PORT) |-> reg_rdata[DW-1:NPIN] == '0);
endmodule

// File: tb/test_gpio_port_ovr.sv
module test_gpio_port_ovr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [4:0] per_out_en = '0, per_out_data = '0, per_force_out = '0, per_force_in = '0;
    logic       seg_en = 1'b0, rst_pin_off = 1'b0, od_pwm_en = 1'b0, od_tx_en = 1'b0, shdn_active = 1'b0;
    logic [5:0] pad_in = '0;
    logic [4:0] pad_out, pad_oe, pad_od;
    logic [5:0] pin_sync;

    int tests = 0;
    int fails = 0;
    logic [4:0] m_lat, m_dir, m_ana;

    always #2 clk = ~clk;

    gpio_port_ovr i_gpio_port_ovr (.*);

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic e_val(int i);
        return per_out_en[i] ? per_out_data[i] : m_lat[i];
    endfunction
    function automatic logic e_odsel(int i);
        return per_out_en[i] && ((i == 0 && od_pwm_en) || (i == 1 && od_tx_en));
    endfunction
    function automatic logic e_out(int i);
        return e_odsel(i) ? 1'b0 : e_val(i);
    endfunction
    function automatic logic e_oe(int i);
        logic w;
        w = per_force_out[i] ? 1'b1 : (per_force_in[i] ? 1'b0 : ~m_dir[i]);
        if (i == 4 && seg_en) return 1'b0;
        if (i == 0 && shdn_active && per_out_en[0]) return 1'b0;
        if (e_odsel(i)) return w & ~e_val(i);
        return w;
    endfunction
    function automatic logic [7:0] e_port();
        logic [7:0] r;
        r = '0;
        for (int i = 0; i < 5; i++)
            r[i] = pad_in[i] & ~m_ana[i] & ~(i == 4 && seg_en);
        r[5] = pad_in[5] & rst_pin_off;
        return r;
    endfunction

    task automatic wr_reg(logic [1:0] a, logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
        case (a)
            2'd1: m_lat = d[4:0];
            2'd2: m_dir = d[4:0];
            2'd3: m_ana = d[4:0];
            default: ;
        endcase
    endtask

    task automatic rd_check(string req, logic [1:0] a, logic [7:0] exp);
        reg_addr = a;
        #1;
        check(req, reg_rdata, exp);
    endtask

    task automatic settle();
        repeat (2) @(negedge clk);
        #1;
    endtask

    task automatic check_pads(string req);
        logic [4:0] eo, ee, ed;
        for (int i = 0; i < 5; i++) begin
            eo[i] = e_out(i); ee[i] = e_oe(i); ed[i] = e_odsel(i);
        end
        check({req, " pad_out"}, {3'b0, pad_out}, {3'b0, eo});
        check({req, " pad_oe"},  {3'b0, pad_oe},  {3'b0, ee});
        check({req, " pad_od"},  {3'b0, pad_od},  {3'b0, ed});
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd1234;
        void'($urandom(seed));
        m_lat = 5'h00; m_dir = 5'h1F; m_ana = 5'h1F;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset values
        rd_check("R1 dir", 2'd2, 8'h1F);
        rd_check("R1 lat", 2'd1, 8'h00);
        rd_check("R1 ana", 2'd3, 8'h1F);
        check_pads("R1");

        // R2 writes, port write inert
        wr_reg(2'd1, 8'hF5);
        rd_check("R2 lat", 2'd1, 8'h15);
        wr_reg(2'd0, 8'hFF);
        rd_check("R2 port write lat", 2'd1, 8'h15);
        rd_check("R2 port write dir", 2'd2, 8'h1F);
        rd_check("R2 port write ana", 2'd3, 8'h1F);

        // R4 plain output, analog has no effect on output
        wr_reg(2'd2, 8'h00);
        #1; check_pads("R4 ana set");
        wr_reg(2'd3, 8'h00);
        #1; check_pads("R4 ana clear");

        // R3 / R11 sync latency: after one edge not yet visible
        @(negedge clk); pad_in = 6'h3F; rst_pin_off = 1'b1;
        @(negedge clk); #1;
        check("R11 one edge", {2'b0, pin_sync}, 8'h00);
        @(negedge clk); #1;
        check("R11 two edges", {2'b0, pin_sync}, 8'h3F);
        rd_check("R3 port", 2'd0, e_port());
        wr_reg(2'd3, 8'h05);
        rd_check("R3 analog reads 0", 2'd0, 8'h3A);

        // R8 reset pin gate
        rst_pin_off = 1'b0;
        rd_check("R8 reset pin on", 2'd0, 8'h1A);

        // R7 segment
        seg_en = 1'b1; #1;
        check("R7 oe4", {7'b0, pad_oe[4]}, 8'h0);
        rd_check("R7 port bit4", 2'd0, 8'h0A);
        seg_en = 1'b0;

        // R6 force direction, register untouched
        wr_reg(2'd2, 8'h1F);
        per_force_out = 5'h1F; per_force_in = 5'h03; #1;
        check("R6 force out wins", {3'b0, pad_oe}, 8'h1F);
        per_force_out = 5'h00; #1;
        wr_reg(2'd2, 8'h00);
        per_force_in = 5'h1F; #1;
        check("R6 force in", {3'b0, pad_oe}, 8'h00);
        rd_check("R6 dir kept", 2'd2, 8'h00);
        per_force_in = 5'h00;

        // R5 peripheral data
        wr_reg(2'd1, 8'h00);
        per_out_en = 5'h1F; per_out_data = 5'h0A; #1;
        check("R5 peripheral data", {3'b0, pad_out}, 8'h0A);

        // R9 open drain both pins, data high then low
        od_pwm_en = 1'b1; od_tx_en = 1'b1; per_out_data = 5'h03; #1;
        check_pads("R9 od high");
        check("R9 oe released", {6'b0, pad_oe[1:0]}, 8'h0);
        per_out_data = 5'h00; #1;
        check("R9 oe low", {6'b0, pad_oe[1:0]}, 8'h3);
        check("R9 out low", {6'b0, pad_out[1:0]}, 8'h0);

        // R10 shutdown with forced output
        per_force_out = 5'h01; shdn_active = 1'b1; #1;
        check("R10 shutdown", {7'b0, pad_oe[0]}, 8'h0);
        check_pads("R10");
        shdn_active = 1'b0; per_force_out = '0; od_pwm_en = 0; od_tx_en = 0; per_out_en = '0;

        // random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 2) == 0)
                wr_reg(2'($urandom), 8'($urandom));
            @(negedge clk);
            per_out_en    = 5'($urandom) & 5'($urandom);
            per_out_data  = 5'($urandom);
            per_force_out = 5'($urandom) & 5'($urandom) & 5'($urandom);
            per_force_in  = 5'($urandom) & 5'($urandom);
            seg_en        = 1'($urandom);
            rst_pin_off   = 1'($urandom);
            od_pwm_en     = 1'($urandom);
            od_tx_en      = 1'($urandom);
            shdn_active   = ($urandom_range(0, 3) == 0);
            pad_in        = 6'($urandom);
            settle();
            check_pads("R4 R5 R6 R9 R10 random");
            check("R11 random", {2'b0, pin_sync}, {2'b0, pad_in});
            rd_check("R3 R7 R8 random", 2'd0, e_port());
            rd_check("R6 dir random", 2'd2, {3'b0, m_dir});
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        tests++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule